// File: doc/BRIEF.md
# Parallel Sampling-Converter Host Sequencer

This block is the host-side master for a successive-approximation converter that is driven through a chip-select strobe, a read/convert mode line and a byte-select line, and that reports completion by pulling an active-low done flag. One request on a valid/ready port starts one sample. The request picks whether the converter stays in standby after the conversion or powers its reference down, and whether the result is taken as one 16-bit read or as two byte reads.

Each conversion uses three chip-select falls. At the first the mode line is low and acquisition starts. At the second the mode line carries the power choice and the conversion starts. The block then waits for the done flag, and at the third fall the mode line is high so that the converter drives its result. Every pulse width, setup gap, data-valid delay and bus-release gap is a cycle count set by a parameter. When the converter may have lost its reference (after reset, after a shutdown-mode conversion, or after a timeout), the block first stretches the acquisition to the reference wake-up time. It then runs one full conversion whose result it throws away, and only then runs the real one. The result leaves on a single-cycle response pulse. A flag on that pulse marks a conversion whose done flag never came.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is held and just after it, chip-select is high (inactive), the request port is ready and no response is signalled.
- R2: A request is taken only when the port shows ready, and ready is shown only while no sample is in progress. A request held valid during a sample starts nothing further.
- R3: Each chip-select low pulse lasts at least CSL_CYC cycles, and each high interval between two falls lasts at least CSH_CYC cycles.
- R4: The mode line is 0 at the first fall of a conversion. At the second fall it is 1 for a shutdown request and 0 for a standby request or a discarded warm-up conversion. It is 1 at the third fall, and it does not change while chip-select is low.
- R5: The first and second falls of a conversion are at least ACQ_CYC cycles apart.
- R6: The third fall happens only while the done flag is low. If the flag is still high EOC_TMO_CYC cycles after the second fall, the sample is abandoned: the response pulse comes with the error flag at 1 and the data at 0.
- R7: In 16-bit mode, the data bus is sampled no earlier than DO_CYC cycles after the third fall, and the response data is the full bus.
- R8: In byte mode, the low byte is read from bus bits [7:0] with byte-select at 0. Byte-select is then raised to 1, and the high byte is read from the same bits no earlier than DO_CYC cycles later. The response word is {high, low}. Byte-select stays 0 in 16-bit mode.
- R9: After the result has been read, chip-select stays high for at least BR_CYC cycles before the next fall and before the response pulse.
- R10: After reset, after a shutdown-mode sample and after an abandoned sample, the next request first runs one warm-up conversion. Its first and second falls are at least WAKE_CYC cycles apart and its mode line is 0 at the second fall. That conversion gives six falls in all, and only the second conversion's result is returned.
- R11: After a standby-mode sample, the next request runs exactly one conversion of three falls.
- R12: Each accepted request produces exactly one response pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_shutdown | input | 1 | 1: power the reference down after the sample; 0: stay in standby |
| req_byte | input | 1 | 1: two byte reads; 0: one 16-bit read |
| conv_cs_n | output | 1 | Converter chip-select, active low |
| conv_rc | output | 1 | Converter read/convert mode line |
| conv_hben | output | 1 | Byte select: 1 high byte, 0 low byte |
| conv_eoc_n | input | 1 | Converter done flag, active low |
| conv_data | input | 16 | Converter data bus (bits [7:0] carry bytes in byte mode) |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | 16 | Captured sample, valid with rsp_valid |
| rsp_error | output | 1 | Done-flag timeout, valid with rsp_valid |

## Verification
The hardest situations to reach are the recovery paths. In one, a sample is abandoned because the done flag never falls, and the following request must rebuild a known converter state with a long acquisition and a discarded conversion. The other is a read taken a cycle too early. The bench's converter model can be told never to finish a conversion, which forces the timeout, and it drives the bitwise inverse of the sample until the data-valid delay has run from the last fall or byte-select change, so an early capture shows up as a wrong word. The model also adds a running conversion count to each sample, so a skipped or extra warm-up conversion changes the returned value.

// File: rtl/adcm_pkg.sv
package adcm_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_F1_SET,
        ST_F1_LOW,
        ST_ACQ_HI,
        ST_F2_SET,
        ST_F2_LOW,
        ST_F2_HI,
        ST_EOC_WAIT,
        ST_F3_SET,
        ST_F3_LOW,
        ST_F3_HIB,
        ST_RELINQ,
        ST_ABORT
    } seq_st_e;

    typedef struct packed {
        logic shutdown;
        logic byte_mode;
    } host_req_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } split_word_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // states in which chip-select is driven low
    function automatic logic strobe_low(input seq_st_e s);
        return (s == ST_F1_LOW) || (s == ST_F2_LOW) || (s == ST_F3_LOW) || (s == ST_F3_HIB);
    endfunction

endpackage

// File: rtl/adcm_timer.sv
module adcm_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/adcm_capture.sv
module adcm_capture
    import adcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_full,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] word
);
    split_word_t w_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            w_q <= '0;
        else if (cap_full)
            w_q <= din;
        else if (cap_lo)
            w_q.lo <= din[BYTE_W-1:0];
        else if (cap_hi)
            w_q.hi <= din[BYTE_W-1:0];
    end

    assign word = w_q;

    AST_CAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cap_full, cap_lo, cap_hi, clr})); // R8
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adcm_pkg::*;
#(
    parameter int unsigned CSL_CYC     = 12,
    parameter int unsigned CSH_CYC     = 8,
    parameter int unsigned ACQ_CYC     = 220,
    parameter int unsigned WAKE_CYC    = 2000000,
    parameter int unsigned DO_CYC      = 16,
    parameter int unsigned BR_CYC      = 16,
    parameter int unsigned EOC_TMO_CYC = 1200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_shutdown,
    input  logic              req_byte,
    output logic              conv_cs_n,
    output logic              conv_rc,
    output logic              conv_hben,
    input  logic              conv_eoc_n,
    input  logic [WORD_W-1:0] conv_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_error
);
    localparam int unsigned RD_CYC   = max2(CSL_CYC, DO_CYC);
    localparam int unsigned REL_CYC  = max2(CSH_CYC, BR_CYC);
    localparam int unsigned GAP_MAX  = max2(max2(RD_CYC, REL_CYC), CSL_CYC);
    localparam int unsigned LONG_MAX = max2(max2(ACQ_CYC, WAKE_CYC), EOC_TMO_CYC);
    localparam int GAP_W  = $clog2(GAP_MAX + 1);
    localparam int LONG_W = $clog2(LONG_MAX + 1);
    localparam int RUN_W  = GAP_W + 1;

    localparam logic [GAP_W-1:0]  G_CSL  = GAP_W'(CSL_CYC);
    localparam logic [GAP_W-1:0]  G_CSH  = GAP_W'(CSH_CYC);
    localparam logic [GAP_W-1:0]  G_RD   = GAP_W'(RD_CYC);
    localparam logic [GAP_W-1:0]  G_DO   = GAP_W'(DO_CYC);
    localparam logic [GAP_W-1:0]  G_REL  = GAP_W'(REL_CYC);
    localparam logic [LONG_W-1:0] L_ACQ  = LONG_W'(ACQ_CYC);
    localparam logic [LONG_W-1:0] L_WAKE = LONG_W'(WAKE_CYC);
    localparam logic [LONG_W-1:0] L_TMO  = LONG_W'(EOC_TMO_CYC);

    seq_st_e   state, nxt;
    host_req_t req_q;
    logic      dummy_q, wake_q, asleep_q;
    logic      rsp_valid_q, rsp_error_q;

    logic              gap_ld, long_ld, gap_done, long_done;
    logic [GAP_W-1:0]  gap_val;
    logic [LONG_W-1:0] long_val;
    logic              cap_full, cap_lo, cap_hi, cap_clr;
    logic              accept, finish, abort;

    adcm_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_ld), .value(gap_val), .done(gap_done));

    adcm_timer #(.W(LONG_W)) u_long (
        .clk(clk), .rst(rst), .load(long_ld), .value(long_val), .done(long_done));

    adcm_capture u_cap (
        .clk(clk), .rst(rst), .clr(cap_clr), .cap_full(cap_full),
        .cap_lo(cap_lo), .cap_hi(cap_hi), .din(conv_data), .word(rsp_data));

    always_comb begin
        nxt      = state;
        gap_ld   = 1'b0;
        gap_val  = '0;
        long_ld  = 1'b0;
        long_val = '0;
        cap_full = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        cap_clr  = 1'b0;
        accept   = 1'b0;
        finish   = 1'b0;
        abort    = 1'b0;
        case (state)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1;
                nxt    = ST_F1_SET;
            end
            ST_F1_SET: begin
                gap_ld = 1'b1; gap_val = G_CSL;
                long_ld = 1'b1; long_val = wake_q ? L_WAKE : L_ACQ;
                nxt = ST_F1_LOW;
            end
            ST_F1_LOW: if (gap_done) begin
                gap_ld = 1'b1; gap_val = G_CSH;
                nxt = ST_ACQ_HI;
            end
            ST_ACQ_HI: if (gap_done && long_done) nxt = ST_F2_SET;
            ST_F2_SET: begin
                gap_ld = 1'b1; gap_val = G_CSL;
                long_ld = 1'b1; long_val = L_TMO;
                nxt = ST_F2_LOW;
            end
            ST_F2_LOW: if (gap_done) begin
                gap_ld = 1'b1; gap_val = G_CSH;
                nxt = ST_F2_HI;
            end
            ST_F2_HI: if (gap_done) nxt = ST_EOC_WAIT;
            ST_EOC_WAIT: begin
                if (!conv_eoc_n)    nxt = ST_F3_SET;
                else if (long_done) nxt = ST_ABORT;
            end
            ST_F3_SET: begin
                gap_ld = 1'b1; gap_val = G_RD;
                nxt = ST_F3_LOW;
            end
            ST_F3_LOW: if (gap_done) begin
                gap_ld = 1'b1;
                if (req_q.byte_mode) begin
                    cap_lo = 1'b1; gap_val = G_DO; nxt = ST_F3_HIB;
                end else begin
                    cap_full = 1'b1; gap_val = G_REL; nxt = ST_RELINQ;
                end
            end
            ST_F3_HIB: if (gap_done) begin
                cap_hi = 1'b1;
                gap_ld = 1'b1; gap_val = G_REL;
                nxt = ST_RELINQ;
            end
            ST_RELINQ: if (gap_done) begin
                if (dummy_q) nxt = ST_F1_SET;
                else begin
                    finish = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            ST_ABORT: begin
                abort   = 1'b1;
                cap_clr = 1'b1;
                nxt     = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            dummy_q     <= 1'b0;
            wake_q      <= 1'b0;
            asleep_q    <= 1'b1;
            rsp_valid_q <= 1'b0;
            rsp_error_q <= 1'b0;
        end else begin
            state       <= nxt;
            rsp_valid_q <= finish || abort;
            rsp_error_q <= abort;
            if (accept) begin
                req_q.shutdown  <= req_shutdown;
                req_q.byte_mode <= req_byte;
                dummy_q         <= asleep_q;
                wake_q          <= asleep_q;
            end
            if (state == ST_RELINQ && gap_done && dummy_q) begin
                dummy_q <= 1'b0;
                wake_q  <= 1'b0;
            end
            if (finish) asleep_q <= req_q.shutdown;
            if (abort)  asleep_q <= 1'b1;
        end
    end

    always_comb begin
        case (state)
            ST_F2_SET, ST_F2_LOW:             conv_rc = dummy_q ? 1'b0 : req_q.shutdown;
            ST_F3_SET, ST_F3_LOW, ST_F3_HIB:  conv_rc = 1'b1;
            default:                          conv_rc = 1'b0;
        endcase
    end

    assign conv_cs_n = !strobe_low(state);
    assign conv_hben = (state == ST_F3_HIB);
    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_error = rsp_error_q;

    // ---------------- protocol checks ----------------
    logic             cs_d;
    logic [RUN_W-1:0] run_q;
    logic [1:0]       fall_idx;
    logic             cs_fall;

    assign cs_fall = !conv_cs_n && cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d     <= 1'b1;
            run_q    <= '1;
            fall_idx <= '0;
        end else begin
            cs_d <= conv_cs_n;
            if (conv_cs_n != cs_d) run_q <= '0;
            else if (run_q != '1)  run_q <= run_q + 1'b1;
            if (rsp_valid_q && rsp_error_q) fall_idx <= '0;
            else if (cs_fall) fall_idx <= (fall_idx == 2'd2) ? 2'd0 : fall_idx + 2'd1;
        end
    end

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> conv_cs_n); // R2
    AST_CS_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (conv_cs_n && !cs_d) |-> (run_q >= RUN_W'(CSL_CYC))); // R3
    AST_CS_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        cs_fall |-> (run_q >= RUN_W'(CSH_CYC))); // R3
    AST_RC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!conv_cs_n && !cs_d) |-> $stable(conv_rc)); // R4
    AST_FIRST_FALL_RC: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && fall_idx == 2'd0) |-> !conv_rc); // R4
    AST_THIRD_FALL_EOC: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && fall_idx == 2'd2) |-> (!conv_eoc_n && conv_rc)); // R6
    AST_HBEN_BYTE_ONLY: assert property (@(posedge clk) disable iff (rst)
        conv_hben |-> (req_q.byte_mode && !conv_cs_n)); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R12
endmodule

// File: tb/adc_host_ctrl_tb.sv
`timescale 1ns/1ps
module adc_host_ctrl_tb_top;
    localparam int CSL = 3, CSH = 2, ACQ = 20, WAKE = 200, DOC = 4, BR = 3, TMO = 100;
    localparam int NEVER = 32'h7fff_ffff;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, req_valid, req_ready, req_shutdown, req_byte;
    logic        conv_cs_n, conv_rc, conv_hben, conv_eoc_n;
    logic [15:0] conv_data, rsp_data;
    logic        rsp_valid, rsp_error;

    adc_host_ctrl #(.CSL_CYC(CSL), .CSH_CYC(CSH), .ACQ_CYC(ACQ), .WAKE_CYC(WAKE),
                    .DO_CYC(DOC), .BR_CYC(BR), .EOC_TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_shutdown(req_shutdown), .req_byte(req_byte), .conv_cs_n(conv_cs_n),
        .conv_rc(conv_rc), .conv_hben(conv_hben), .conv_eoc_n(conv_eoc_n),
        .conv_data(conv_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_error(rsp_error));

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int          conv_lat;
    logic [15:0] ain;
    bit          b_mode;
    int          m_idx, m_cnt, m_since, m_conv_no;
    bit          m_busy, m_read, m_prev_cs, m_prev_hb;
    logic [15:0] m_sample;

    always @(negedge clk) begin
        if (rst) begin
            m_idx = 0; m_cnt = 0; m_since = 0; m_conv_no = 0;
            m_busy = 0; m_read = 0; m_prev_cs = 1; m_prev_hb = 0;
            m_sample = '0;
            conv_eoc_n <= 1'b1;
            conv_data  <= 16'h0;
        end else begin
            if (rsp_valid && rsp_error) begin
                m_idx = 0; m_busy = 0;
            end
            if (m_prev_cs && !conv_cs_n) begin
                if (m_idx == 1) begin
                    m_sample = ain + 16'(m_conv_no);
                    m_conv_no++;
                    m_busy = 1; m_cnt = 0;
                end
                if (m_idx == 2) begin
                    m_read = 1; m_since = 0;
                end
                m_idx = (m_idx == 2) ? 0 : m_idx + 1;
            end else if (!m_prev_cs && conv_cs_n) begin
                if (m_read) begin
                    m_read = 0;
                    conv_eoc_n <= 1'b1;
                end
            end else if (m_read) begin
                m_since++;
            end
            if (m_read && conv_hben != m_prev_hb) m_since = 0;
            if (m_busy) begin
                if (m_cnt >= conv_lat) begin
                    conv_eoc_n <= 1'b0;
                    m_busy = 0;
                end else m_cnt++;
            end
            if (m_read && m_since >= DOC)
                conv_data <= b_mode ? {8'h5A, (conv_hben ? m_sample[15:8] : m_sample[7:0])} : m_sample;
            else
                conv_data <= ~m_sample;
            m_prev_cs = conv_cs_n;
            m_prev_hb = conv_hben;
        end
    end

    // ---------------- protocol monitor ----------------
    bit exp_wake, exp_shut, exp_byte, mon_on;
    int mon_falls, mrun, macq, rgap;
    bit p_cs, p_rc;

    always @(negedge clk) begin
        if (rst || !mon_on) begin
            p_cs = 1; p_rc = conv_rc; mrun = 1000; macq = 0; rgap = 1000;
        end else begin
            if (p_cs && !conv_cs_n) begin
                int k, ph;
                k = mon_falls; ph = k % 3;
                chk(mrun >= CSH, "R3", "cs high width", mrun, CSH);
                if (ph == 0) begin
                    chk(conv_rc == 0, "R4", "rc at first fall", conv_rc, 0);
                    if (k > 0) chk(mrun >= BR, "R9", "release before next fall", mrun, BR);
                end
                if (ph == 1) begin
                    bit warm;
                    warm = exp_wake && (k == 1);
                    chk(conv_rc == (warm ? 1'b0 : exp_shut), "R4", "rc at second fall",
                        conv_rc, warm ? 0 : exp_shut);
                    if (warm) chk(macq >= WAKE, "R10", "wake acquisition", macq, WAKE);
                    else      chk(macq >= ACQ, "R5", "acquisition gap", macq, ACQ);
                end
                if (ph == 2) begin
                    chk(conv_rc == 1, "R4", "rc at third fall", conv_rc, 1);
                    chk(conv_eoc_n == 0, "R6", "eoc low at third fall", conv_eoc_n, 0);
                end
                if (ph == 0) macq = 0;
                mon_falls++;
                mrun = 1;
            end else if (!p_cs && conv_cs_n) begin
                chk(mrun >= CSL, "R3", "cs low width", mrun, CSL);
                mrun = 1; rgap = 0;
            end else begin
                mrun++;
                if (!conv_cs_n && conv_rc != p_rc) chk(0, "R4", "rc changed while cs low", conv_rc, p_rc);
                if (!exp_byte && conv_hben) chk(0, "R8", "hben in 16-bit mode", conv_hben, 0);
            end
            macq++; rgap++;
            p_cs = conv_cs_n; p_rc = conv_rc;
        end
    end

    // ---------------- stimulus ----------------
    bit          asleep_exp;
    int          exp_conv;

    task automatic run_req(input bit shut, input bit bytem, input logic [15:0] a,
                           input int lat, input bit exp_err, input bit hold);
        logic [15:0] exp_d;
        bit busy_bad, got;
        int falls_seen;
        exp_wake = asleep_exp; exp_shut = shut; exp_byte = bytem;
        b_mode = bytem; ain = a; conv_lat = lat; mon_falls = 0;
        exp_d = exp_err ? 16'h0 : a + 16'(exp_conv + (asleep_exp ? 1 : 0));
        exp_conv += exp_err ? 1 : (asleep_exp ? 2 : 1);
        @(negedge clk);
        chk(req_ready == 1, "R2", "ready when idle", req_ready, 1);
        req_valid = 1; req_shutdown = shut; req_byte = bytem;
        @(negedge clk);
        if (!hold) req_valid = 0;
        busy_bad = 0; got = 0;
        for (int i = 0; i < 5000 && !got; i++) begin
            if (rsp_valid) got = 1;
            else begin
                if (req_ready) busy_bad = 1;
                @(negedge clk);
            end
        end
        req_valid = 0;
        chk(got, "R12", "response arrived", got, 1);
        chk(!busy_bad, "R2", "ready low while busy", busy_bad, 0);
        chk(rsp_error == exp_err, "R6", "error flag", rsp_error, exp_err);
        chk(rsp_data == exp_d, bytem ? "R8" : "R7", "response data", rsp_data, exp_d);
        if (!exp_err) begin
            chk(mon_falls == (exp_wake ? 6 : 3), exp_wake ? "R10" : "R11",
                "falls per request", mon_falls, exp_wake ? 6 : 3);
            chk(rgap >= BR, "R9", "release before response", rgap, BR);
        end
        falls_seen = mon_falls;
        @(negedge clk);
        chk(rsp_valid == 0, "R12", "single-cycle response", rsp_valid, 0);
        if (hold) begin
            repeat (30) @(negedge clk);
            chk(mon_falls == falls_seen && conv_cs_n, "R2", "held valid started nothing",
                mon_falls, falls_seen);
        end
        asleep_exp = exp_err ? 1'b1 : shut;
    endtask

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; req_valid = 0; req_shutdown = 0; req_byte = 0;
        ain = 16'h0; conv_lat = 10; b_mode = 0; mon_on = 0;
        asleep_exp = 1; exp_conv = 0; mon_falls = 0;
        exp_wake = 0; exp_shut = 0; exp_byte = 0;
        repeat (4) @(negedge clk);
        chk(conv_cs_n == 1, "R1", "cs high in reset", conv_cs_n, 1);
        chk(req_ready == 1, "R1", "ready in reset", req_ready, 1);
        chk(rsp_valid == 0, "R1", "no response in reset", rsp_valid, 0);
        rst = 0;
        mon_on = 1;
        repeat (5) @(negedge clk);
        chk(conv_cs_n == 1 && rsp_valid == 0, "R1", "quiet after reset", conv_cs_n, 1);

        run_req(0, 0, 16'h1234, 12, 0, 0);  // R10 first request warms up
        run_req(0, 0, 16'hFFF0, 30, 0, 0);  // R11 standby, one conversion
        run_req(0, 1, 16'hA5C3, 7, 0, 0);   // R8 byte mode
        run_req(1, 0, 16'h0001, 20, 0, 0);  // R4 shutdown choice
        run_req(0, 1, 16'h8000, 15, 0, 0);  // R10 wake after shutdown
        run_req(0, 0, 16'h4321, 9, 0, 1);   // R2 valid held during busy
        run_req(0, 0, 16'h7777, NEVER, 1, 0); // R6 timeout
        run_req(0, 0, 16'h2468, 10, 0, 0);  // R10 wake after timeout
        run_req(0, 0, 16'h1357, TMO - 20, 0, 0); // R6 slow but in time

        for (int n = 0; n < 24; n++) begin
            bit sh, by;
            sh = ($urandom % 4) == 0;
            by = $urandom % 2;
            run_req(sh, by, 16'($urandom), 5 + ($urandom % 80), 0, ($urandom % 6) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule